// File: doc/BRIEF.md
# FPU Status and Exception Register

This block is the 32-bit status/control register that sits beside a small processor's floating-point unit. It stores four mode bits: a register bank swap, a paired (64-bit) transfer size, double precision, and a denormal-as-zero mode. It also stores a 2-bit rounding field and three groups of exception bits: cause, enable and flag. Software reads and writes the whole word through a simple port. The FPU drives the other side with an operation-start strobe and a per-operation exception report.

Each new FPU operation wipes the cause group before it records anything. Flags collect exceptions over many operations and only a software write clears them. One extra cause bit, the error condition, has no enable bit and no flag bit, and it always requests a trap. The block also reports the current modes, a trap request, and a reserved-mode indication for the combination of paired transfer with double precision.

Top module: `fpu_csr`

## Requirements
- R1: After reset the register reads 0x00040001: denormal-as-zero (bit 18) is 1, the rounding field (bits 1:0) is 01, and all other bits are 0.
- R2: A software write stores bits 21:0 as given. Bits 31:22 always read 0. Read data shows the stored word with no added cycle of delay.
- R3: When `op_start` is high, the cause bits 17:12 are cleared in that cycle before any exception is recorded. This also applies to a value that software writes in the same cycle.
- R4: When `exc_valid` is high, every set bit of `exc_vec` sets its cause bit and, for V/Z/O/U/I, its flag bit. The encoding is exc_vec[5]=E (cause bit 17), [4]=V (16/flag 6), [3]=Z (15/flag 5), [2]=O (14/flag 4), [1]=U (13/flag 3), [0]=I (12/flag 2).
- R5: A flag bit, once set, stays 1 across later FPU operations until a software write clears it.
- R6: The error cause bit E has no flag bit. Reporting only E leaves flag bits 6:2 unchanged.
- R7: `trap_req` is 1 when the E cause bit is set. It is also 1 when any V/Z/O/U/I cause bit is set and its enable bit is set. The enable bits are V=11, Z=10, O=9, U=8, I=7.
- R8: `mode_reserved` is 1 exactly when the pair-transfer bit (bit 20) and the double-precision bit (bit 19) are both 1. The stored bits are kept as written.
- R9: If a software write and an exception report occur in the same cycle, the exception bits are ORed on top of the written value.
- R10: The outputs `mode_bank` (bit 21), `mode_pair` (bit 20), `mode_dbl` (bit 19) and `mode_daz` (bit 18) follow the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current register contents |
| op_start | input | 1 | An FPU operation begins this cycle |
| exc_valid | input | 1 | `exc_vec` is valid this cycle |
| exc_vec | input | 6 | Exceptions raised: E,V,Z,O,U,I from bit 5 down |
| mode_bank | output | 1 | Register bank swap mode |
| mode_pair | output | 1 | Paired 64-bit transfer mode |
| mode_dbl | output | 1 | Double-precision mode |
| mode_daz | output | 1 | Denormal-as-zero mode |
| trap_req | output | 1 | Enabled exception or error pending in cause |
| mode_reserved | output | 1 | Pair and double modes both set |

## Verification
The bench drives operation start together with an exception report and checks that only the new cause is left. A design that merged the old cause bits would show stale bits there. It reports exceptions over several operations and checks that the flags keep accumulating. A design that cleared flags with cause would lose the earlier ones. It reports the error condition alone and checks two things: the flags do not move, and a trap is raised with every enable at zero. It also collides a software write with an exception report, and a software write with operation start. A design with the wrong priority in either case would show the written value unchanged, or stale cause bits.

// File: rtl/fpu_csr_pkg.sv
package fpu_csr_pkg;
    localparam int XLEN      = 32;
    localparam int NEXC      = 5;          // exceptions that own enable and flag bits
    localparam int NCAUSE    = NEXC + 1;   // plus the error cause
    localparam int CAUSE_LSB = 12;
    localparam int EN_LSB    = 7;
    localparam int FLAG_LSB  = 2;
    localparam int DAZ_BIT   = 18;
    localparam int DBL_BIT   = 19;
    localparam int PAIR_BIT  = 20;
    localparam int BANK_BIT  = 21;
    localparam int RND_W     = 2;
    localparam logic [XLEN-1:0] RST_VAL = 32'h0004_0001;
    localparam logic [XLEN-1:0] WR_MASK = 32'h003F_FFFF;
endpackage

// File: rtl/fpu_csr_cause.sv
module fpu_csr_cause #(
    parameter int W = 6
) (
    input  logic [W-1:0] cur,
    input  logic         op_start,
    input  logic         exc_valid,
    input  logic [W-1:0] exc_vec,
    output logic [W-1:0] nxt
);
    always_comb begin
        nxt = op_start ? '0 : cur;
        if (exc_valid)
            nxt = nxt | exc_vec;
    end
endmodule

// File: rtl/fpu_csr_flag.sv
module fpu_csr_flag #(
    parameter int W = 5
) (
    input  logic [W-1:0] cur,
    input  logic         exc_valid,
    input  logic [W-1:0] exc_vec,
    output logic [W-1:0] nxt
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        assign nxt[i] = cur[i] | (exc_valid & exc_vec[i]);
    end
endmodule

// File: rtl/fpu_csr_trap.sv
module fpu_csr_trap #(
    parameter int W = 5
) (
    input  logic [W:0]   cause,
    input  logic [W-1:0] enable,
    output logic         trap
);
    assign trap = cause[W] | (|(cause[W-1:0] & enable));
endmodule

// File: rtl/fpu_csr.sv
module fpu_csr
    import fpu_csr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_we,
    input  logic [XLEN-1:0] sw_wdata,
    output logic [XLEN-1:0] sw_rdata,
    input  logic            op_start,
    input  logic            exc_valid,
    input  logic [NEXC:0]   exc_vec,
    output logic            mode_bank,
    output logic            mode_pair,
    output logic            mode_dbl,
    output logic            mode_daz,
    output logic            trap_req,
    output logic            mode_reserved
);
    localparam int CAUSE_MSB = CAUSE_LSB + NCAUSE - 1;
    localparam int EN_MSB    = EN_LSB + NEXC - 1;
    localparam int FLAG_MSB  = FLAG_LSB + NEXC - 1;

    logic [XLEN-1:0]   csr_q;
    logic [XLEN-1:0]   base;
    logic [XLEN-1:0]   csr_d;
    logic [NCAUSE-1:0] cause_d;
    logic [NEXC-1:0]   flag_d;

    // software write takes the place of the held value before FPU updates
    assign base = sw_we ? (sw_wdata & WR_MASK) : csr_q;

    fpu_csr_cause #(.W(NCAUSE)) u_cause (
        .cur       (base[CAUSE_MSB:CAUSE_LSB]),
        .op_start  (op_start),
        .exc_valid (exc_valid),
        .exc_vec   (exc_vec),
        .nxt       (cause_d)
    );

    fpu_csr_flag #(.W(NEXC)) u_flag (
        .cur       (base[FLAG_MSB:FLAG_LSB]),
        .exc_valid (exc_valid),
        .exc_vec   (exc_vec[NEXC-1:0]),
        .nxt       (flag_d)
    );

    always_comb begin
        csr_d                     = base;
        csr_d[CAUSE_MSB:CAUSE_LSB] = cause_d;
        csr_d[FLAG_MSB:FLAG_LSB]   = flag_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            csr_q <= RST_VAL;
        else
            csr_q <= csr_d;
    end

    fpu_csr_trap #(.W(NEXC)) u_trap (
        .cause  (csr_q[CAUSE_MSB:CAUSE_LSB]),
        .enable (csr_q[EN_MSB:EN_LSB]),
        .trap   (trap_req)
    );

    assign sw_rdata      = csr_q;
    assign mode_bank     = csr_q[BANK_BIT];
    assign mode_pair     = csr_q[PAIR_BIT];
    assign mode_dbl      = csr_q[DBL_BIT];
    assign mode_daz      = csr_q[DAZ_BIT];
    assign mode_reserved = csr_q[PAIR_BIT] & csr_q[DBL_BIT];
endmodule

// File: rtl/fpu_csr_chk.sv
module fpu_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sw_we,
    input logic [31:0] sw_wdata,
    input logic [31:0] sw_rdata,
    input logic        op_start,
    input logic        exc_valid,
    input logic [5:0]  exc_vec,
    input logic        trap_req,
    input logic        mode_reserved
);
    // R2: upper bits never hold anything
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rdata[31:22] == 10'd0);

    // R3: start without a report leaves cause empty
    a_r3_cause_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !exc_valid) |=> sw_rdata[17:12] == 6'd0);

    // R4: reported exceptions appear in cause and flag
    a_r4_exc_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> ((sw_rdata[17:12] & $past(exc_vec)) == $past(exc_vec))
                  && ((sw_rdata[6:2] & $past(exc_vec[4:0])) == $past(exc_vec[4:0])));

    // R5: flags never drop without a software write
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> (sw_rdata[6:2] & $past(sw_rdata[6:2])) == $past(sw_rdata[6:2]));

    // R7: a pending error cause always requests a trap
    a_r7_error_traps: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rdata[17] |-> trap_req);

    // R8: reserved indication follows the two mode bits
    a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        mode_reserved == (sw_rdata[20] && sw_rdata[19]));
endmodule

bind fpu_csr fpu_csr_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_we         (sw_we),
    .sw_wdata      (sw_wdata),
    .sw_rdata      (sw_rdata),
    .op_start      (op_start),
    .exc_valid     (exc_valid),
    .exc_vec       (exc_vec),
    .trap_req      (trap_req),
    .mode_reserved (mode_reserved)
);

// File: tb/fpu_csr_tb.sv
module fpu_csr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        op_start = 1'b0;
    logic        exc_valid = 1'b0;
    logic [5:0]  exc_vec = '0;
    logic        mode_bank, mode_pair, mode_dbl, mode_daz, trap_req, mode_reserved;
    int          ntests = 0;
    int          nfail = 0;

    always #2 clk = ~clk;   // 250 MHz

    fpu_csr u_dut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .op_start(op_start), .exc_valid(exc_valid),
        .exc_vec(exc_vec), .mode_bank(mode_bank), .mode_pair(mode_pair),
        .mode_dbl(mode_dbl), .mode_daz(mode_daz), .trap_req(trap_req),
        .mode_reserved(mode_reserved)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [31:0] wd, input logic st,
                        input logic ev, input logic [5:0] v);
        @(negedge clk);
        sw_we = we; sw_wdata = wd; op_start = st; exc_valid = ev; exc_vec = v;
        @(posedge clk);
        #1;
        sw_we = 1'b0; op_start = 1'b0; exc_valid = 1'b0; exc_vec = '0;
    endtask

    task automatic t_reset;
        check("R1 reset value", sw_rdata, 32'h0004_0001);
        check("R1 daz at reset", {31'd0, mode_daz}, 32'd1);
        check("R1 no trap at reset", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_write;
        step(1, 32'hFFFF_FFFF, 0, 0, 6'd0);
        check("R2 masked write", sw_rdata, 32'h003F_FFFF);
        check("R10 modes all set", {28'd0, mode_bank, mode_pair, mode_dbl, mode_daz}, 32'hF);
        check("R8 reserved on", {31'd0, mode_reserved}, 32'd1);
        step(1, 32'h0, 0, 0, 6'd0);
        check("R2 write zero", sw_rdata, 32'h0);
    endtask

    task automatic t_exceptions;
        step(0, 0, 0, 1, 6'b010100);
        check("R4 V and O recorded", sw_rdata, 32'h0001_4050);
        check("R7 no trap when disabled", {31'd0, trap_req}, 32'd0);
        step(0, 0, 1, 0, 6'd0);
        check("R3 cause cleared, R5 flags kept", sw_rdata, 32'h0000_0050);
        step(0, 0, 1, 1, 6'b000001);
        check("R3 new cause only, R5 flags accumulate", sw_rdata, 32'h0000_1054);
    endtask

    task automatic t_error;
        step(0, 0, 1, 1, 6'b100000);
        check("R6 error leaves flags", sw_rdata, 32'h0002_0054);
        check("R7 error traps", {31'd0, trap_req}, 32'd1);
    endtask

    task automatic t_trap_enable;
        step(1, 32'h0000_0400, 0, 0, 6'd0);
        step(0, 0, 1, 1, 6'b001000);
        check("R7 enabled Z cause", sw_rdata, 32'h0000_8420);
        check("R7 enabled Z traps", {31'd0, trap_req}, 32'd1);
        step(0, 0, 1, 1, 6'b000100);
        check("R7 disabled O", sw_rdata, 32'h0000_4430);
        check("R7 disabled O no trap", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_collision;
        step(1, 32'h0, 0, 1, 6'b000010);
        check("R9 exception over write", sw_rdata, 32'h0000_2008);
        step(1, 32'h0003_0000, 1, 0, 6'd0);
        check("R3 start clears written cause", sw_rdata, 32'h0);
    endtask

    task automatic t_modes;
        step(1, 32'h0018_0000, 0, 0, 6'd0);
        check("R8 reserved stored", sw_rdata, 32'h0018_0000);
        check("R8 reserved flagged", {31'd0, mode_reserved}, 32'd1);
        step(1, 32'h0008_0000, 0, 0, 6'd0);
        check("R8 double alone not reserved", {31'd0, mode_reserved}, 32'd0);
        step(1, 32'h0020_0000, 0, 0, 6'd0);
        check("R10 bank only", {28'd0, mode_bank, mode_pair, mode_dbl, mode_daz}, 32'h8);
    endtask

    initial begin
        #(200000 * 4);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_write();
        t_exceptions();
        t_error();
        t_trap_enable();
        t_collision();
        t_modes();
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule